// File: doc/BRIEF.md
# Ring-Triggered Power Mode Controller

This block steps a line receiver through three power levels. In standby nothing is enabled. A ring burst seen by an external timer pulls the active-low ring-detect input down. The block then moves to a partial level, where only the ring-analysis logic runs. When the host asks for power by pulling the active-low power-up request down, the block moves to the full level and enables the complete receive datapath. That request may simply be the qualified-ring indication looped back through `host_wake_n`. When the request is released, the block returns to standby and waits for the next sequence.

Both control inputs arrive already synchronized and debounced. The state is held in a register on the system clock, and every enable is decoded from that register. A ring that ends before any power-up request arrives sends the block back to standby. In that case the block emits a one-cycle clear pulse that resets the ring qualifier.

Top module: `ring_pwr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows state code 2'b00, `ana_en`=0, `rx_en`=0 and `qual_clr`=0.
- R2: In standby (code 2'b00), with `ring_det_n`=1 and `pwr_req_n`=1, the block stays in standby with no enable asserted.
- R3: In standby, with `ring_det_n`=0 and `pwr_req_n`=1, the block is in partial power (code 2'b01) one cycle later, with `ana_en`=1 and `rx_en`=0. It remains there while ring detect stays low and no request is present.
- R4: With `pwr_req_n`=0 in standby or in partial power, the block is in full power (code 2'b10) one cycle later, with `rx_en`=1 and `ana_en`=0. The request wins over ring detect.
- R5: In full power, `ring_det_n` has no effect: while `pwr_req_n`=0 the block stays in full power whatever ring detect does.
- R6: In full power, `pwr_req_n`=1 returns the block to standby one cycle later.
- R7: In partial power, with `ring_det_n`=1 and `pwr_req_n`=1, the block is in standby one cycle later, and `qual_clr` is high for exactly that one cycle.
- R8: `host_wake_n` is low exactly when `ring_qual` is high and the registered state is partial power. This is a combinational path from `ring_qual` in the default variant.
- R9: The state code never takes the value 2'b11, and `ana_en` and `rx_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_det_n | input | 1 | Ring detect from external timer, active low |
| pwr_req_n | input | 1 | Host power-up request, active low |
| ring_qual | input | 1 | Qualified-ring indication from the ring qualifier |
| ana_en | output | 1 | Enable for the ring-analysis logic |
| rx_en | output | 1 | Enable for the full receive datapath |
| state_code | output | 2 | Registered state: 00 standby, 01 partial, 10 full |
| qual_clr | output | 1 | One-cycle pulse that resets the ring qualifier after a ring is abandoned |
| host_wake_n | output | 1 | Qualified ring handed to the host, active low |

## Verification
The assertions check every transition of the state machine on every cycle:
- each arrival from standby and from partial power;
- the fact that full power holds regardless of ring detect;
- the clear pulse on fallback and its one-cycle length;
- the exclusivity of the enables and the illegal code.

The bench compares every output against a behavioural model on every clock. Two things can only be shown by its scenarios: that a looped-back qualified ring actually carries the block from partial to full power, and that a fresh ring arriving immediately after a fallback starts a new sequence cleanly.

// File: rtl/ring_pwr_pkg.sv
package ring_pwr_pkg;
   typedef enum logic [1:0] {
      PS_STBY = 2'b00,
      PS_PART = 2'b01,
      PS_FULL = 2'b10
   } pwr_state_t;

   localparam int unsigned CODE_W = 2;
endpackage

// File: rtl/rps_next_state.sv
module rps_next_state
   import ring_pwr_pkg::*;
(
   input  pwr_state_t cur,
   input  logic       ring_act,
   input  logic       req_act,
   output pwr_state_t nxt,
   output logic       fallback
);
   always_comb begin
      nxt      = cur;
      fallback = 1'b0;
      unique case (cur)
         PS_STBY: begin
            if (req_act)       nxt = PS_FULL;
            else if (ring_act) nxt = PS_PART;
         end
         PS_PART: begin
            if (req_act) nxt = PS_FULL;
            else if (!ring_act) begin
               nxt      = PS_STBY;
               fallback = 1'b1;
            end
         end
         PS_FULL: begin
            if (!req_act) nxt = PS_STBY;
         end
         default: nxt = PS_STBY;
      endcase
   end
endmodule

// File: rtl/rps_state_reg.sv
module rps_state_reg
   import ring_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  pwr_state_t nxt,
   input  logic       fallback,
   output pwr_state_t state,
   output logic       clr_pulse
);
   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= PS_STBY;
         clr_pulse <= 1'b0;
      end else begin
         state     <= nxt;
         clr_pulse <= fallback;
      end
   end
endmodule

// File: rtl/rps_wake_out.sv
module rps_wake_out #(
   parameter bit WAKE_REG = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic ring_qual,
   input  logic in_partial,
   output logic wake_n
);
   logic wake_raw_n;
   assign wake_raw_n = ~(ring_qual & in_partial);

   generate
      if (WAKE_REG) begin : g_reg
         logic wake_q_n;
         always_ff @(posedge clk) begin
            if (rst) wake_q_n <= 1'b1;
            else     wake_q_n <= wake_raw_n;
         end
         assign wake_n = wake_q_n;
      end else begin : g_comb
         assign wake_n = wake_raw_n;
      end
   endgenerate
endmodule

// File: rtl/ring_pwr_seq.sv
module ring_pwr_seq
   import ring_pwr_pkg::*;
#(
   parameter bit WAKE_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ring_det_n,
   input  logic                pwr_req_n,
   input  logic                ring_qual,
   output logic                ana_en,
   output logic                rx_en,
   output logic [CODE_W-1:0]   state_code,
   output logic                qual_clr,
   output logic                host_wake_n
);
   initial begin
      if (CODE_W != $bits(pwr_state_t))
         $error("state code width does not match state type");
   end

   pwr_state_t st_q, st_d;
   logic       fb;

   rps_next_state u_next (
      .cur      (st_q),
      .ring_act (~ring_det_n),
      .req_act  (~pwr_req_n),
      .nxt      (st_d),
      .fallback (fb)
   );

   rps_state_reg u_reg (
      .clk       (clk),
      .rst       (rst),
      .nxt       (st_d),
      .fallback  (fb),
      .state     (st_q),
      .clr_pulse (qual_clr)
   );

   assign ana_en     = (st_q == PS_PART);
   assign rx_en      = (st_q == PS_FULL);
   assign state_code = st_q;

   rps_wake_out #(.WAKE_REG(WAKE_REG)) u_wake (
      .clk        (clk),
      .rst        (rst),
      .ring_qual  (ring_qual),
      .in_partial (ana_en),
      .wake_n     (host_wake_n)
   );
endmodule

// File: rtl/ring_pwr_seq_chk.sv
module ring_pwr_seq_chk #(
   parameter bit WAKE_REG = 1'b0
) (
   input logic       clk,
   input logic       rst,
   input logic       ring_det_n,
   input logic       pwr_req_n,
   input logic       ring_qual,
   input logic       ana_en,
   input logic       rx_en,
   input logic [1:0] state_code,
   input logic       qual_clr,
   input logic       host_wake_n
);
   p_reset_stby_r1: assert property (@(posedge clk)
      rst |=> (state_code == 2'b00 && !ana_en && !rx_en && !qual_clr));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (state_code == 2'b00 && ring_det_n && pwr_req_n) |=> (state_code == 2'b00 && !ana_en && !rx_en));

   p_ring_partial_r3: assert property (@(posedge clk) disable iff (rst)
      (state_code != 2'b10 && !ring_det_n && pwr_req_n) |=> (state_code == 2'b01 && ana_en && !rx_en));

   p_req_full_r4: assert property (@(posedge clk) disable iff (rst)
      (state_code != 2'b10 && !pwr_req_n) |=> (state_code == 2'b10 && rx_en && !ana_en));

   p_full_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (state_code == 2'b10 && !pwr_req_n) |=> (state_code == 2'b10));

   p_full_release_r6: assert property (@(posedge clk) disable iff (rst)
      (state_code == 2'b10 && pwr_req_n) |=> (state_code == 2'b00));

   p_fallback_clr_r7: assert property (@(posedge clk) disable iff (rst)
      (state_code == 2'b01 && ring_det_n && pwr_req_n) |=> (state_code == 2'b00 && qual_clr));

   p_clr_single_r7: assert property (@(posedge clk) disable iff (rst)
      qual_clr |=> !qual_clr);

   p_legal_code_r9: assert property (@(posedge clk) disable iff (rst)
      (state_code != 2'b11) && !(ana_en && rx_en));

   generate
      if (!WAKE_REG) begin : g_wake_chk
         p_wake_partial_r8: assert property (@(posedge clk) disable iff (rst)
            !host_wake_n |-> (ana_en && ring_qual));
      end
   endgenerate
endmodule

bind ring_pwr_seq ring_pwr_seq_chk #(.WAKE_REG(WAKE_REG)) u_chk (.*);

// File: tb/ring_pwr_seq_bench.sv
module ring_pwr_seq_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ring_det_n = 1'b1;
   logic       pwr_req_n = 1'b1;
   logic       ring_qual = 1'b0;
   logic       ana_en, rx_en, qual_clr, host_wake_n;
   logic [1:0] state_code;

   int checks = 0;
   int errors = 0;
   bit loopback = 1'b0;

   always #2 clk = ~clk;

   ring_pwr_seq u_ring_pwr_seq (
      .clk(clk), .rst(rst), .ring_det_n(ring_det_n), .pwr_req_n(pwr_req_n),
      .ring_qual(ring_qual), .ana_en(ana_en), .rx_en(rx_en),
      .state_code(state_code), .qual_clr(qual_clr), .host_wake_n(host_wake_n)
   );

   // Reference model: 0 standby, 1 partial, 2 full
   int    m_state = 0;
   bit    m_clr = 1'b0;
   string m_tag = "R1";

   always @(posedge clk) begin
      if (rst) begin
         m_state <= 0; m_clr <= 1'b0; m_tag <= "R1";
      end else begin
         m_clr <= 1'b0;
         if (m_state == 0) begin
            if (!pwr_req_n)       begin m_state <= 2; m_tag <= "R4"; end
            else if (!ring_det_n) begin m_state <= 1; m_tag <= "R3"; end
            else                  m_tag <= "R2";
         end else if (m_state == 1) begin
            if (!pwr_req_n)      begin m_state <= 2; m_tag <= "R4"; end
            else if (ring_det_n) begin m_state <= 0; m_clr <= 1'b1; m_tag <= "R7"; end
            else                 m_tag <= "R3";
         end else begin
            if (pwr_req_n) begin m_state <= 0; m_tag <= "R6"; end
            else           m_tag <= "R5";
         end
      end
   end

   // Compare on the falling edge, away from the active edge
   always @(negedge clk) begin
      logic [4:0] exp_v, act_v;
      logic       exp_w;
      exp_v = {m_state[1:0], m_state == 1, m_state == 2, m_clr};
      act_v = {state_code, ana_en, rx_en, qual_clr};
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s code/ana/rx/clr act=%b exp=%b t=%0t", m_tag, act_v, exp_v, $time);
      end
      if (state_code == 2'b11 || (ana_en && rx_en)) begin
         errors++;
         $display("FAIL R9 act=%b exp=legal", act_v);
      end
      if (!rst) begin
         exp_w = ~(ring_qual & (m_state == 1));
         checks++;
         if (host_wake_n !== exp_w) begin
            errors++;
            $display("FAIL R8 host_wake_n act=%b exp=%b t=%0t", host_wake_n, exp_w, $time);
         end
      end
      if (loopback) pwr_req_n = host_wake_n;
   end

   task automatic step(input logic rd, input logic rq, input logic qu, input int n);
      repeat (n) begin
         @(negedge clk);
         ring_det_n = rd; pwr_req_n = rq; ring_qual = qu;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      step(1, 1, 0, 4);              // R2 idle
      step(0, 1, 0, 5);              // R3 ring enters partial
      step(0, 1, 1, 2);              // R8 wake low in partial
      step(1, 1, 0, 3);              // R7 fallback with clear pulse
      step(0, 1, 0, 1);              // R3 ring right after fallback
      step(1, 1, 0, 2);              // R7 fallback again
      step(1, 0, 0, 3);              // R4 request straight from standby
      step(0, 0, 1, 4);              // R5 ring ignored in full, R8 wake high
      step(1, 0, 0, 2);              // R5
      step(1, 1, 0, 3);              // R6 release
      step(0, 0, 0, 2);              // R4 request beats ring
      step(1, 1, 0, 2);
      step(0, 1, 0, 3);              // R3 then loopback of qualified ring
      @(negedge clk); ring_qual = 1'b1; loopback = 1'b1;
      repeat (6) @(negedge clk);     // R4 via looped-back host_wake_n
      loopback = 1'b0;
      step(0, 1, 0, 3);              // R6 release, then R3
      step(1, 1, 0, 2);
      rst = 1'b1; step(0, 0, 0, 2);  // R1 reset overrides inputs
      rst = 1'b0;
      for (int i = 0; i < 3000; i++)
         step(($urandom % 4) != 0, ($urandom % 5) != 0, $urandom % 2, 1);
      step(1, 1, 0, 3);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule